// File: doc/BRIEF.md
# Configuration Security and Signature Controller

This block guards the configuration store of a programmable logic device. It holds a 64-bit user signature, made of eight bytes, for free-form data such as a project tag, revision or date. It also holds a small configuration store, a bank of preloadable state registers and a one-shot security bit. All access goes through a single command port. The block accepts one command per cycle while `cmd_ready` is high. Reads answer on the following cycle through `rsp_valid` and `rsp_data`.

The security bit takes effect at the clock edge that accepts the secure command. From the next cycle on, the block refuses verify reads of the store, programming of the store and register preload. A refused command raises `deny` for one cycle and leaves `rsp_data` at zero. The signature stays readable and writable in every state. The only way back is a full erase. It clears the signature at once, then wipes the store one word per cycle, and releases the security bit only when the wipe ends.

The controller is a four-state machine:
- `ST_IDLE`: accepts commands.
- `ST_REPLY`: presents read data for one cycle.
- `ST_REFUSE`: pulses `deny` for one cycle.
- `ST_WIPE`: clears the store.

Transitions:
- `ST_IDLE`→`ST_REPLY` on an allowed signature or verify read.
- `ST_IDLE`→`ST_REFUSE` on a refused command.
- `ST_IDLE`→`ST_WIPE` on erase.
- `ST_REPLY`→`ST_IDLE` and `ST_REFUSE`→`ST_IDLE` after one cycle.
- `ST_WIPE`→`ST_IDLE` after the last word is cleared.
- All other commands keep `ST_IDLE`.

Top module: `cfgsec_ctrl`

## Requirements
- R1: After reset, `cmd_ready`=1, `rsp_valid`=0, `deny`=0, `rsp_data`=0 and `secured`=0. `preload_q`, every signature byte and every store word are zero.
- R2: Opcode 1 (signature write) stores `cmd_wdata` into the signature byte selected by `cmd_addr[2:0]`. The other seven bytes are unchanged.
- R3: Opcode 2 (signature read) returns the byte at `cmd_addr[2:0]` on `rsp_data`, with `rsp_valid`=1, in the cycle after acceptance. `cmd_ready` is 0 in that cycle and 1 in the cycle after it.
- R4: Signature reads and writes behave identically whether `secured` is 0 or 1.
- R5: While unsecured, opcode 3 (program) writes `cmd_wdata` to store word `cmd_addr`. Opcode 4 (verify) returns that word on `rsp_data` with `rsp_valid`=1 in the cycle after acceptance.
- R6: While secured, opcodes 3, 4 and 5 are refused: `deny`=1, `rsp_valid`=0 and `rsp_data`=0 for exactly one cycle after acceptance.
- R7: Opcode 6 (secure) sets `secured` in the cycle after acceptance. A verify accepted in that very cycle is already refused.
- R8: While unsecured, opcode 5 (preload) loads `cmd_wdata[7:0]` into `preload_q`. A refused preload leaves `preload_q` unchanged.
- R9: Opcode 7 (erase) holds `cmd_ready` low for exactly 16 cycles. Afterwards `secured`=0, and every signature byte and store word reads zero. `secured` keeps its old value until the wipe ends.
- R10: Once set, `secured` stays 1 through any command other than erase, including a repeated secure.
- R11: Opcode 0 (no operation) and cycles with `cmd_valid`=0 change no output and no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode 0..7 as listed in the requirements |
| cmd_addr | input | 4 | Store word address; low 3 bits select the signature byte |
| cmd_wdata | input | 8 | Write data for signature, store or preload |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| rsp_valid | output | 1 | Read data valid on `rsp_data` |
| rsp_data | output | 8 | Read data; zero when not valid |
| deny | output | 1 | One-cycle refusal pulse |
| secured | output | 1 | Security bit |
| preload_q | output | 8 | Preloadable state registers |

## Verification
The assertions take for granted that `cmd_op`, `cmd_addr` and `cmd_wdata` carry known values whenever `cmd_valid` is high, and that `cmd_valid` itself is never unknown after reset. The stimulus drives every input on the falling edge from the bench's own tasks, so these values are settled before each rising edge. It draws opcodes only from the eight defined codes and addresses only within the 16-word store. It raises `cmd_valid` only when `cmd_ready` is sampled high, so no command is offered to a busy controller.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_SIG_WR   = 3'd1,
        OP_SIG_RD   = 3'd2,
        OP_CFG_PROG = 3'd3,
        OP_CFG_VFY  = 3'd4,
        OP_PRELOAD  = 3'd5,
        OP_SECURE   = 3'd6,
        OP_ERASE    = 3'd7
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REPLY,
        ST_REFUSE,
        ST_WIPE
    } ctl_state_e;
endpackage

// File: rtl/cfgsec_sig_bank.sv
module cfgsec_sig_bank #(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    localparam int IW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          clr,
    input  logic [IW-1:0] idx,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata
);
    logic [BW-1:0] bytes_w [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [BW-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (clr)
                byte_q <= '0;
            else if (we && (idx == IW'(g)))
                byte_q <= wdata;
        end
        assign bytes_w[g] = byte_q;
    end

    assign rdata = bytes_w[idx];

    // R9
    sig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rdata == '0));
endmodule

// File: rtl/cfgsec_cfg_store.sv
module cfgsec_cfg_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cfgsec_fsm.sv
module cfgsec_fsm
    import cfgsec_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NREG   = 8,
    parameter int SIG_IW = 3,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] sig_rdata,
    input  logic [DATA_W-1:0] cfg_rdata,
    output logic              sig_we,
    output logic              sig_clr,
    output logic [SIG_IW-1:0] sig_idx,
    output logic              cfg_we,
    output logic [AW-1:0]     cfg_waddr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              deny,
    output logic              secured,
    output logic [NREG-1:0]   preload_q
);
    ctl_state_e        state_q, state_d;
    cmd_op_e           op;
    logic              sec_q;
    logic [AW-1:0]     wipe_q;
    logic [DATA_W-1:0] data_q;
    logic              accept, refused, wipe_last;

    assign op        = cmd_op_e'(cmd_op);
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign refused   = sec_q && ((op == OP_CFG_VFY) || (op == OP_CFG_PROG) || (op == OP_PRELOAD));
    assign wipe_last = (wipe_q == AW'(DEPTH - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (refused)
                        state_d = ST_REFUSE;
                    else if ((op == OP_SIG_RD) || (op == OP_CFG_VFY))
                        state_d = ST_REPLY;
                    else if (op == OP_ERASE)
                        state_d = ST_WIPE;
                end
            end
            ST_REPLY:  state_d = ST_IDLE;
            ST_REFUSE: state_d = ST_IDLE;
            ST_WIPE:   if (wipe_last) state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sec_q     <= 1'b0;
            wipe_q    <= '0;
            data_q    <= '0;
            preload_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && (op == OP_SECURE))
                sec_q <= 1'b1;
            else if ((state_q == ST_WIPE) && wipe_last)
                sec_q <= 1'b0;
            if (accept && (op == OP_ERASE))
                wipe_q <= '0;
            else if (state_q == ST_WIPE)
                wipe_q <= wipe_q + 1'b1;
            if (accept && (op == OP_SIG_RD))
                data_q <= sig_rdata;
            else if (accept && (op == OP_CFG_VFY))
                data_q <= cfg_rdata;
            if (accept && (op == OP_PRELOAD) && !sec_q)
                preload_q <= cmd_wdata[NREG-1:0];
        end
    end

    // outputs and strobes
    always_comb begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        deny      = 1'b0;
        rsp_data  = '0;
        cfg_we    = 1'b0;
        cfg_waddr = cmd_addr;
        cfg_wdata = cmd_wdata;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                cfg_we    = cmd_valid && (op == OP_CFG_PROG) && !sec_q;
            end
            ST_REPLY: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            ST_REFUSE: deny = 1'b1;
            ST_WIPE: begin
                cfg_we    = 1'b1;
                cfg_waddr = wipe_q;
                cfg_wdata = '0;
            end
        endcase
    end

    assign sig_we  = accept && (op == OP_SIG_WR);
    assign sig_clr = accept && (op == OP_ERASE);
    assign sig_idx = cmd_addr[SIG_IW-1:0];
    assign secured = sec_q;

    // R7
    vfy_after_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_SECURE)) |=> secured);
    // R6
    refuse_vfy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sec_q && (op == OP_CFG_VFY)) |=> (deny && !rsp_valid && (rsp_data == '0)));
    // R6
    deny_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deny |=> !deny);
    // R3
    sig_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_SIG_RD)) |=> (rsp_valid && !deny && !cmd_ready));
    // R10
    sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q && (state_q != ST_WIPE)) |=> sec_q);
    // R9
    erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_ERASE)) |=> (!cmd_ready && (secured == $past(secured))));
endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl
    import cfgsec_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int NREG      = 8,
    parameter int SIG_BYTES = 8,
    localparam int AW       = $clog2(DEPTH),
    localparam int SIG_IW   = $clog2(SIG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              deny,
    output logic              secured,
    output logic [NREG-1:0]   preload_q
);
    logic              sig_we, sig_clr, cfg_we;
    logic [SIG_IW-1:0] sig_idx;
    logic [AW-1:0]     cfg_waddr;
    logic [DATA_W-1:0] cfg_wdata, sig_rdata, cfg_rdata;

    cfgsec_fsm #(.DEPTH(DEPTH), .NREG(NREG), .SIG_IW(SIG_IW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .sig_rdata(sig_rdata), .cfg_rdata(cfg_rdata),
        .sig_we(sig_we), .sig_clr(sig_clr), .sig_idx(sig_idx),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .deny(deny), .secured(secured), .preload_q(preload_q)
    );

    cfgsec_sig_bank #(.NBYTES(SIG_BYTES), .BW(DATA_W)) u_sig (
        .clk(clk), .rst_n(rst_n), .we(sig_we), .clr(sig_clr),
        .idx(sig_idx), .wdata(cmd_wdata), .rdata(sig_rdata)
    );

    cfgsec_cfg_store #(.DEPTH(DEPTH), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr),
        .wdata(cfg_wdata), .raddr(cmd_addr), .rdata(cfg_rdata)
    );
endmodule

// File: tb/cfgsec_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfgsec_ctrl_tb_top;
    import cfgsec_pkg::*;
    localparam int DEPTH = 16;
    localparam int NREG  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic cmd_ready, rsp_valid, deny, secured;
    logic [7:0] rsp_data;
    logic [NREG-1:0] preload_q;

    int checks = 0;
    int fails = 0;
    logic [7:0] sig_m [8];
    logic [7:0] cfg_m [DEPTH];
    logic sec_m = 1'b0;
    logic [NREG-1:0] pre_m = '0;

    always #2 clk = ~clk;

    cfgsec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .deny(deny),
        .secured(secured), .preload_q(preload_q)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic is_refused(input logic [2:0] op, input logic s);
        return s && (op == OP_CFG_VFY || op == OP_CFG_PROG || op == OP_PRELOAD);
    endfunction

    function automatic logic is_read(input logic [2:0] op, input logic s);
        return (op == OP_SIG_RD) || (op == OP_CFG_VFY && !s);
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [2:0] op, input logic [3:0] a, input logic s);
        if (op == OP_SIG_RD) return sig_m[a[2:0]];
        if (op == OP_CFG_VFY && !s) return cfg_m[a];
        return 8'd0;
    endfunction

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [7:0] w);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // issue a non-erase command and check the response against the model
    task automatic do_op(input string req, input logic [2:0] op, input logic [3:0] a, input logic [7:0] w);
        logic rd, rf;
        logic [7:0] ed;
        rd = is_read(op, sec_m);
        rf = is_refused(op, sec_m);
        ed = exp_rdata(op, a, sec_m);
        issue(op, a, w);
        chk({req, " rsp_valid"}, rsp_valid, rd);
        chk({req, " deny"}, deny, rf);
        chk({req, " rsp_data"}, rsp_data, ed);
        if (op == OP_SIG_WR) sig_m[a[2:0]] = w;
        if (op == OP_CFG_PROG && !sec_m) cfg_m[a] = w;
        if (op == OP_PRELOAD && !sec_m) pre_m = w[NREG-1:0];
        if (op == OP_SECURE) sec_m = 1'b1;
        chk({req, " secured"}, secured, sec_m);
        chk({req, " preload_q"}, preload_q, pre_m);
    endtask

    task automatic do_erase(input bit hold_chk);
        int n;
        logic s0;
        s0 = sec_m;
        issue(OP_ERASE, 4'd0, 8'd0);
        if (hold_chk) chk("R9 secured held during wipe", secured, s0);
        n = 0;
        while (!cmd_ready) begin n++; @(negedge clk); end
        chk("R9 busy cycles", n, DEPTH);
        for (int i = 0; i < 8; i++) sig_m[i] = 8'd0;
        for (int i = 0; i < DEPTH; i++) cfg_m[i] = 8'd0;
        sec_m = 1'b0;
        chk("R9 secured cleared", secured, 1'b0);
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [2:0] rop;
        int r;
        unused_seed = $urandom(32'h5EC0_0001);
        for (int i = 0; i < 8; i++) sig_m[i] = 8'd0;
        for (int i = 0; i < DEPTH; i++) cfg_m[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd_ready", cmd_ready, 1'b1);
        chk("R1 rsp_valid", rsp_valid, 1'b0);
        chk("R1 deny", deny, 1'b0);
        chk("R1 rsp_data", rsp_data, 8'd0);
        chk("R1 secured", secured, 1'b0);
        chk("R1 preload_q", preload_q, 8'd0);
        do_op("R1 sig byte 5 zero", OP_SIG_RD, 4'd5, 8'd0);
        do_op("R1 store word 11 zero", OP_CFG_VFY, 4'd11, 8'd0);

        // R2 byte writes, readback of each byte
        for (int i = 0; i < 8; i++) do_op("R2 write", OP_SIG_WR, 4'(i), 8'(8'h31 + i * 7));
        do_op("R2 overwrite byte 3", OP_SIG_WR, 4'd3, 8'hA5);
        for (int i = 0; i < 8; i++) do_op("R2 R3 read", OP_SIG_RD, 4'(i), 8'd0);
        // R3 ready returns one cycle after reply
        @(negedge clk);
        chk("R3 ready after reply", cmd_ready, 1'b1);
        // R3 signature index uses low 3 bits
        do_op("R3 high addr bit ignored", OP_SIG_RD, 4'd11, 8'd0);

        // R5 program and verify
        do_op("R5 prog", OP_CFG_PROG, 4'd0, 8'h5A);
        do_op("R5 prog", OP_CFG_PROG, 4'd15, 8'hC3);
        do_op("R5 verify", OP_CFG_VFY, 4'd0, 8'd0);
        do_op("R5 verify", OP_CFG_VFY, 4'd15, 8'd0);

        // R8 preload
        do_op("R8 preload", OP_PRELOAD, 4'd0, 8'h96);

        // R11 no operation, then idle cycles
        do_op("R11 nop", OP_NOP, 4'd2, 8'hFF);
        repeat (3) @(negedge clk);
        chk("R11 idle rsp_valid", rsp_valid, 1'b0);
        do_op("R11 store kept", OP_CFG_VFY, 4'd15, 8'd0);

        // R7 secure then verify on the very next cycle
        issue(OP_SECURE, 4'd0, 8'd0);
        sec_m = 1'b1;
        chk("R7 secured next cycle", secured, 1'b1);
        issue(OP_CFG_VFY, 4'd0, 8'd0);
        chk("R7 immediate verify denied", deny, 1'b1);
        chk("R7 R6 denied data zero", rsp_data, 8'd0);
        @(negedge clk);
        chk("R6 deny one cycle", deny, 1'b0);

        // R6 refusals, R8 refused preload
        do_op("R6 prog refused", OP_CFG_PROG, 4'd1, 8'h77);
        do_op("R6 R8 preload refused", OP_PRELOAD, 4'd0, 8'h11);
        // R4 signature access while secured
        do_op("R4 sig write secured", OP_SIG_WR, 4'd6, 8'hE1);
        do_op("R4 sig read secured", OP_SIG_RD, 4'd6, 8'd0);
        // R10 repeated secure and other commands keep the bit
        do_op("R10 secure again", OP_SECURE, 4'd0, 8'd0);
        do_op("R10 nop keeps", OP_NOP, 4'd0, 8'd0);

        // R9 erase
        do_erase(1'b1);
        do_op("R9 sig zero", OP_SIG_RD, 4'd6, 8'd0);
        do_op("R9 store zero", OP_CFG_VFY, 4'd15, 8'd0);
        do_op("R9 store zero", OP_CFG_VFY, 4'd0, 8'd0);

        // random mix
        for (int k = 0; k < 600; k++) begin
            r = int'($urandom % 32);
            if (r < 5) rop = OP_SIG_WR;
            else if (r < 9) rop = OP_SIG_RD;
            else if (r < 14) rop = OP_CFG_PROG;
            else if (r < 20) rop = OP_CFG_VFY;
            else if (r < 24) rop = OP_PRELOAD;
            else if (r < 26) rop = OP_SECURE;
            else if (r < 27) rop = OP_ERASE;
            else rop = OP_NOP;
            if (rop == OP_ERASE) do_erase(1'b1);
            else do_op("R2-random R5 R6 R8 R10 mix", rop, 4'($urandom % 16), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule